// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider

This block sits in the feedback path of a frequency synthesiser. It divides a fast input clock by a ratio whose long-term average is an integer N plus a binary fraction. Each output period is N or N+1 input cycles long. A fixed-point phase accumulator picks between the two lengths. The accumulator adds the fraction word once per output period, and its overflow selects the longer length for the next period.

The divide ratio and the fraction are sampled only at the edge that ends an output period. The counter reloads on that same edge, so a new setting never shortens or lengthens a count that is already running. The block emits one single-cycle pulse per output period. Beside the pulse it shows the carry that fixed the length of the period just starting. This lets a neighbour see the modulus sequence directly.

Top module: `fracn_divider`

## Requirements
- R1: While `rst_n` is low, `pulse_out` and `carry_out` are 0, and the accumulator and the counter are cleared. In the cycle after the first rising clock edge with `rst_n` high, `pulse_out` is 1. This is the first output pulse.
- R2: With `div_frac` equal to 0, pulses come every `div_int` cycles and `carry_out` stays 0.
- R3: At each pulse the unsigned K-bit accumulator adds `div_frac` exactly once. The sum wraps modulo 2^K. `carry_out` shown with that pulse is the overflow bit (bit K) of this addition.
- R4: The number of input cycles from one pulse to the next equals `div_int` plus the `carry_out` value shown at the first of the two pulses.
- R5: Starting from reset, the 2^K output periods that follow the first pulse together last exactly `div_int`·2^K + `div_frac` input cycles.
- R6: `pulse_out` is high for exactly one cycle per output period. When the period is one cycle long, it stays high.
- R7: Changes on `div_int` or `div_frac` during an output period do not alter that period's length. They take effect at the edge that ends the period.
- R8: `div_int` = 1 is supported and yields periods of 1 or 2 cycles. `div_int` = 0 is not allowed.
- R9: `carry_out` changes only on the edge that launches a pulse and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| div_int | input | NW | Integer part N of the divide ratio, at least 1 |
| div_frac | input | KW | Fractional part as an unsigned K-bit fraction of 2^K |
| pulse_out | output | 1 | Divided output, one single-cycle pulse per period |
| carry_out | output | 1 | Accumulator overflow that chose the length of the current period |

## Verification
If the accumulator held a wrong value, `carry_out` would differ from the expected overflow sequence within one output period. The error would also show as a 2^K-period cycle total that misses N·2^K + F. A counter that reloaded wrongly or cut a count short would show at the next pulse as a spacing different from N plus the shown carry. If the input sampling happened at the wrong moment, a mid-period setting change would alter the period in progress rather than the following one.

// File: rtl/fracn_pkg.sv
// Package: fracn_pkg
// Shared defaults for the fractional-N divider. The widths here set the
// parameter defaults of every module in the block.
package fracn_pkg;
    // Default width of the integer divide ratio
    localparam int unsigned DEF_INT_W  = 8;
    // Default width of the fractional accumulator
    localparam int unsigned DEF_FRAC_W = 16;

    // Result of one accumulator step: overflow bit and wrapped sum
    typedef struct packed {
        logic        ovf;
        logic [DEF_FRAC_W-1:0] sum;
    } acc_step_t;
endpackage

// File: rtl/fracn_accum.sv
// Module: fracn_accum
// Fixed-point phase accumulator. On each step it adds the fraction word to a
// KW-bit running sum that wraps modulo 2^KW. The overflow of the addition
// is offered combinationally (for the reload in the same edge) and is also
// registered as the carry that belongs to the period being launched.
// Assumes: step is high for exactly one cycle per output period.
module fracn_accum #(
    parameter int unsigned KW = fracn_pkg::DEF_FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [KW-1:0] frac,
    output logic          carry_next,
    output logic          carry_q
);
    localparam int unsigned SW = KW + 1;

    logic [KW-1:0] acc_q;
    logic [SW-1:0] sum_w;

    // Widened addition exposing the overflow bit
    always_comb begin
        sum_w      = {1'b0, acc_q} + {1'b0, frac};
        carry_next = sum_w[KW];
    end

    // Accumulate once per period; hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (step) begin
            acc_q   <= sum_w[KW-1:0];
            carry_q <= sum_w[KW];
        end
    end

    // R3
    wrap_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && frac != '0) |=> (carry_q == (acc_q < $past(acc_q))));

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(acc_q) && $stable(carry_q)));
endmodule

// File: rtl/fracn_counter.sv
// Module: fracn_counter
// Programmable down-counter that sets the modulus. When the count reaches
// zero it reloads to (div_int - 1 + carry_in), so the next period lasts
// div_int or div_int + 1 cycles. The output pulse is registered and follows
// the terminal count by one cycle.
// Assumes: div_int >= 1, so the reload value fits in NW bits.
module fracn_counter #(
    parameter int unsigned NW = fracn_pkg::DEF_INT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] div_int,
    input  logic          carry_in,
    output logic          tc,
    output logic          pulse_q
);
    logic [NW-1:0] cnt_q;
    logic [NW-1:0] reload;

    // Terminal-count decode and next modulus
    always_comb begin
        tc     = (cnt_q == '0);
        reload = div_int - {{(NW-1){1'b0}}, 1'b1} + {{(NW-1){1'b0}}, carry_in};
    end

    // Count down, reload at zero, register the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= tc ? reload : cnt_q - {{(NW-1){1'b0}}, 1'b1};
            pulse_q <= tc;
        end
    end

    // R4
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> (cnt_q == $past(cnt_q) - {{(NW-1){1'b0}}, 1'b1}));

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && cnt_q != '0) |=> !pulse_q);

    // R8
    int_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (div_int != '0));
endmodule

// File: rtl/fracn_divider.sv
// Module: fracn_divider
// Top of the fractional-N dual-modulus divider. The counter's terminal count
// steps the accumulator, and the accumulator's overflow picks the next
// modulus on the same edge. Inputs are sampled only at terminal count.
// Assumes: div_int >= 1.
module fracn_divider #(
    parameter int unsigned NW = fracn_pkg::DEF_INT_W,
    parameter int unsigned KW = fracn_pkg::DEF_FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] div_int,
    input  logic [KW-1:0] div_frac,
    output logic          pulse_out,
    output logic          carry_out
);
    logic tc;
    logic carry_next;

    fracn_counter #(.NW(NW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_int  (div_int),
        .carry_in (carry_next),
        .tc       (tc),
        .pulse_q  (pulse_out)
    );

    fracn_accum #(.KW(KW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (tc),
        .frac       (div_frac),
        .carry_next (carry_next),
        .carry_q    (carry_out)
    );

    // R9
    carry_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry_out) |-> pulse_out);
endmodule

// File: tb/tb_fracn_divider.sv
`timescale 1ns/1ps
module tb_fracn_divider;
    localparam int NW   = 8;
    localparam int KW   = 8;
    localparam int NPER = 1 << KW;
    localparam int NV   = 7;

    // stimulus table: N, F, expected cycles over 2^K periods (N*2^K + F)
    localparam int VN [NV] = '{10, 10, 10, 3, 1, 7, 12};
    localparam int VF [NV] = '{26, 128, 230, 255, 77, 1, 0};
    localparam int VT [NV] = '{2586, 2688, 2790, 1023, 333, 1793, 3072};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] div_int = 8'd10;
    logic [KW-1:0] div_frac = '0;
    logic          pulse_out;
    logic          carry_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fracn_divider #(.NW(NW), .KW(KW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_int   (div_int),
        .div_frac  (div_frac),
        .pulse_out (pulse_out),
        .carry_out (carry_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reset, check idle state, release, check first pulse (R1)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pulse_out == 1'b0, "R1 pulse in reset", pulse_out, 0);
        chk(carry_out == 1'b0, "R1 carry in reset", carry_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pulse_out == 1'b1, "R1 first pulse", pulse_out, 1);
    endtask

    // count cycles to next pulse; tally carry changes and width errors
    task automatic gap(input int exp_len, output int g, inout int stab, inout int wid);
        logic c0;
        c0 = carry_out;
        g = 0;
        do begin
            @(negedge clk);
            g++;
            if (!pulse_out && carry_out != c0) stab++;
            if (g == 1 && exp_len > 1 && pulse_out) wid++;
        end while (!pulse_out && g < 5000);
    endtask

    task automatic run_vec(input int n, input int f, input int tot);
        int acc_m = 0, c, s, g, cyc = 0;
        int carry_err = 0, gap_err = 0, stab = 0, wid = 0;
        div_int  = n[NW-1:0];
        div_frac = f[KW-1:0];
        do_reset();
        for (int p = 0; p < NPER; p++) begin
            s     = acc_m + f;
            c     = s >> KW;
            acc_m = s & (NPER - 1);
            if (carry_out != c[0]) carry_err++;
            gap(n + c, g, stab, wid);
            if (g != n + c) gap_err++;
            cyc += g;
        end
        chk(carry_err == 0, (f == 0) ? "R2 carry stays 0" : "R3 carry sequence", carry_err, 0);
        chk(gap_err == 0, (n == 1) ? "R8 spacing N=1" : "R4 spacing", gap_err, 0);
        chk(cyc == tot, "R5 total cycles", cyc, tot);
        chk(stab == 0, "R9 carry held", stab, 0);
        chk(wid == 0, "R6 pulse width", wid, 0);
    endtask

    initial begin
        int g, st, wd;
        // table walk
        for (int v = 0; v < NV; v++) run_vec(VN[v], VF[v], VT[v]);

        // R7: change settings mid-period
        div_int  = 8'd5;
        div_frac = 8'd0;
        do_reset();
        div_int  = 8'd9;
        div_frac = 8'd200;
        st = 0; wd = 0;
        gap(5, g, st, wd);
        chk(g == 5, "R7 running period kept", g, 5);
        chk(carry_out == 1'b0, "R3 carry after 0+200", carry_out, 0);
        gap(9, g, st, wd);
        chk(g == 9, "R7 new N applied", g, 9);
        chk(carry_out == 1'b1, "R3 carry after 200+200 wraps", carry_out, 1);
        gap(10, g, st, wd);
        chk(g == 10, "R4 N+1 after carry", g, 10);
        chk(st == 0, "R9 carry held directed", st, 0);

        // R2: plain division by 4
        div_int  = 8'd4;
        div_frac = 8'd0;
        do_reset();
        gap(4, g, st, wd);
        chk(g == 4 && carry_out == 1'b0, "R2 divide by 4", g, 4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule